// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block decides whether a request seen on the primary side of a PCI-to-PCI bridge should be claimed and forwarded downstream. It rebuilds three programmable forwarding windows (I/O, non-prefetchable memory and prefetchable memory) from the packed base and limit register fields. Each window has its own granularity and an optional upper-half extension. It also adds the fixed legacy VGA ranges when the VGA control bit is set.

The window values are captured into registers on a single-cycle update strobe. The configuration logic pulses the strobe after any write that touches the command register, the I/O base/limit pair, the span from the memory base through the I/O upper-16 registers, or the bridge control register. Requests are decoded against the captured windows. The claim result appears one clock after the request.

Top module: `bridge_window_decoder`

## Requirements
- R1: After reset, `claim_valid`, `claim` and `claim_win` are 0, and every window, including the VGA ranges, is disabled until the first `cfg_update` pulse.
- R2: I/O window base = `io_base_lo[7:4]` placed at address bits 15:12. When `io_base_lo[3:0]` equals 1, `io_base_hi` is placed at bits 31:16; otherwise those bits are 0. The limit is built the same way from `io_limit_lo`/`io_limit_hi`, with bits 11:0 forced to ones. Only `req_addr[31:0]` is compared for I/O requests.
- R3: Memory window base = `mem_base[15:4]` at bits 31:20. The limit is `mem_limit[15:4]` at bits 31:20 with bits 19:0 forced to ones. Bits 63:32 of both are 0.
- R4: Prefetchable window base = `pf_base[15:4]` at bits 31:20, plus `pf_base_hi` at bits 63:32 when `pf_base[3:0]` equals 1. The limit is built the same way from `pf_limit`/`pf_limit_hi`, with bits 19:0 forced to ones.
- R5: `cmd_io_en` gates the I/O window. `cmd_mem_en` gates both memory windows. A gated window claims nothing.
- R6: A window whose limit is below its base claims nothing.
- R7: While `ctl_vga_en` is set, I/O addresses 0x3B0–0x3BB and 0x3C0–0x3DF and memory addresses 0xA0000–0xBFFFF are claimed. These ranges do not depend on the command enables.
- R8: Priority for memory requests is prefetchable, then memory, then VGA memory. For I/O requests it is the I/O window, then the VGA I/O ranges.
- R9: Register inputs and enables take effect only in the cycle after a `cfg_update` pulse. Changes without a pulse are ignored.
- R10: `claim_valid` equals `req_valid` of the previous cycle. `claim` and `claim_win` come from that request. `claim_win` encodings: 0 none, 1 I/O, 2 memory, 3 prefetchable, 4 VGA I/O, 5 VGA memory. `claim` is 1 exactly when `claim_win` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_update | input | 1 | Capture strobe for window registers |
| io_base_lo | input | 8 | I/O base byte (type in [3:0]) |
| io_limit_lo | input | 8 | I/O limit byte (type in [3:0]) |
| io_base_hi | input | 16 | I/O base bits 31:16 |
| io_limit_hi | input | 16 | I/O limit bits 31:16 |
| mem_base | input | 16 | Memory base word |
| mem_limit | input | 16 | Memory limit word |
| pf_base | input | 16 | Prefetchable base word (type in [3:0]) |
| pf_limit | input | 16 | Prefetchable limit word (type in [3:0]) |
| pf_base_hi | input | 32 | Prefetchable base bits 63:32 |
| pf_limit_hi | input | 32 | Prefetchable limit bits 63:32 |
| cmd_io_en | input | 1 | I/O space enable |
| cmd_mem_en | input | 1 | Memory space enable |
| ctl_vga_en | input | 1 | Legacy VGA forwarding enable |
| req_valid | input | 1 | Request present |
| req_addr | input | 64 | Request address |
| req_is_io | input | 1 | 1 for I/O space, 0 for memory |
| claim_valid | output | 1 | Result for the previous cycle's request |
| claim | output | 1 | Request is forwarded |
| claim_win | output | 3 | Matched window code |

## Verification
On every cycle, the assertions check the following:
- the one-cycle relation between a request and its result;
- that `claim` agrees with the window code;
- that captured windows hold still between update pulses;
- that an enabled window never has a limit below its base;
- that a window written while its space is disabled stays disabled;
- that a VGA code appears only while the captured VGA bit is set.

Only the bench's scenarios can show the following:
- the actual window arithmetic: granularity, upper-half extension selected by the type bits, and exact boundary addresses;
- the priority among overlapping windows;
- that register changes without an update pulse leave decoding unchanged.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int ADDR_W    = 64;
  localparam int IO_W      = 32;
  localparam int IO_GRAN   = 12;
  localparam int MEM_GRAN  = 20;
  localparam int N_WIN     = 3;
  localparam int N_VGA     = 3;
  localparam int IO_HI_W   = IO_W - 16;
  localparam int MEM_HI_W  = ADDR_W - 32;
  localparam logic [3:0] TYPE_WIDE = 4'h1;

  localparam int IDX_IO   = 0;
  localparam int IDX_MEM  = 1;
  localparam int IDX_PREF = 2;

  typedef enum logic [2:0] {
    WIN_NONE    = 3'd0,
    WIN_IO      = 3'd1,
    WIN_MEM     = 3'd2,
    WIN_PREF    = 3'd3,
    WIN_VGA_IO  = 3'd4,
    WIN_VGA_MEM = 3'd5
  } win_e;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] limit;
  } win_t;
endpackage

// File: rtl/bwd_range_match.sv
module bwd_range_match #(
  parameter int AW = 64
) (
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic above_base;
  logic below_limit;

  always_comb begin
    above_base  = (addr >= base);
    below_limit = (addr <= limit);
    hit         = en && above_base && below_limit;
  end
endmodule

// File: rtl/bwd_window_regs.sv
module bwd_window_regs
  import bwd_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   upd,
  input  logic [7:0]             io_base_lo,
  input  logic [7:0]             io_limit_lo,
  input  logic [IO_HI_W-1:0]     io_base_hi,
  input  logic [IO_HI_W-1:0]     io_limit_hi,
  input  logic [15:0]            mem_base,
  input  logic [15:0]            mem_limit,
  input  logic [15:0]            pf_base,
  input  logic [15:0]            pf_limit,
  input  logic [MEM_HI_W-1:0]    pf_base_hi,
  input  logic [MEM_HI_W-1:0]    pf_limit_hi,
  input  logic                   io_en,
  input  logic                   mem_en,
  input  logic                   vga_en,
  output win_t [N_WIN-1:0]       wins_q,
  output logic                   vga_q
);
  localparam logic [IO_GRAN-1:0]  IO_ONES  = '1;
  localparam logic [MEM_GRAN-1:0] MEM_ONES = '1;

  win_t [N_WIN-1:0] wins_d;
  logic             vga_d;
  logic [IO_W-1:0]  io_b, io_l;
  logic [ADDR_W-1:0] mem_b, mem_l, pf_b, pf_l;
  logic             io_b_wide, io_l_wide, pf_b_wide, pf_l_wide;

  // next-state: rebuild windows from the packed fields
  always_comb begin
    io_b_wide = (io_base_lo[3:0]  == TYPE_WIDE);
    io_l_wide = (io_limit_lo[3:0] == TYPE_WIDE);
    pf_b_wide = (pf_base[3:0]     == TYPE_WIDE);
    pf_l_wide = (pf_limit[3:0]    == TYPE_WIDE);

    io_b  = {(io_b_wide ? io_base_hi  : {IO_HI_W{1'b0}}), io_base_lo[7:4],  {IO_GRAN{1'b0}}};
    io_l  = {(io_l_wide ? io_limit_hi : {IO_HI_W{1'b0}}), io_limit_lo[7:4], IO_ONES};
    mem_b = {{MEM_HI_W{1'b0}}, mem_base[15:4],  {MEM_GRAN{1'b0}}};
    mem_l = {{MEM_HI_W{1'b0}}, mem_limit[15:4], MEM_ONES};
    pf_b  = {(pf_b_wide ? pf_base_hi  : {MEM_HI_W{1'b0}}), pf_base[15:4],  {MEM_GRAN{1'b0}}};
    pf_l  = {(pf_l_wide ? pf_limit_hi : {MEM_HI_W{1'b0}}), pf_limit[15:4], MEM_ONES};

    wins_d = wins_q;
    vga_d  = vga_q;
    if (upd) begin
      wins_d[IDX_IO].base    = {{(ADDR_W-IO_W){1'b0}}, io_b};
      wins_d[IDX_IO].limit   = {{(ADDR_W-IO_W){1'b0}}, io_l};
      wins_d[IDX_IO].en      = io_en && (io_l >= io_b);
      wins_d[IDX_MEM].base   = mem_b;
      wins_d[IDX_MEM].limit  = mem_l;
      wins_d[IDX_MEM].en     = mem_en && (mem_l >= mem_b);
      wins_d[IDX_PREF].base  = pf_b;
      wins_d[IDX_PREF].limit = pf_l;
      wins_d[IDX_PREF].en    = mem_en && (pf_l >= pf_b);
      vga_d                  = vga_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wins_q <= '0;
      vga_q  <= 1'b0;
    end else if (upd) begin
      wins_q <= wins_d;
      vga_q  <= vga_d;
    end
  end

  assert_hold_without_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> ($stable(wins_q) && $stable(vga_q)));

  generate
    for (genvar k = 0; k < N_WIN; k++) begin : g_chk
      assert_enabled_not_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wins_q[k].en |-> (wins_q[k].base <= wins_q[k].limit));
    end
  endgenerate

  assert_io_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !io_en) |=> !wins_q[IDX_IO].en);
  assert_mem_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !mem_en) |=> (!wins_q[IDX_MEM].en && !wins_q[IDX_PREF].en));
endmodule

// File: rtl/bridge_window_decoder.sv
module bridge_window_decoder
  import bwd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_update,
  input  logic [7:0]          io_base_lo,
  input  logic [7:0]          io_limit_lo,
  input  logic [15:0]         io_base_hi,
  input  logic [15:0]         io_limit_hi,
  input  logic [15:0]         mem_base,
  input  logic [15:0]         mem_limit,
  input  logic [15:0]         pf_base,
  input  logic [15:0]         pf_limit,
  input  logic [31:0]         pf_base_hi,
  input  logic [31:0]         pf_limit_hi,
  input  logic                cmd_io_en,
  input  logic                cmd_mem_en,
  input  logic                ctl_vga_en,
  input  logic                req_valid,
  input  logic [63:0]         req_addr,
  input  logic                req_is_io,
  output logic                claim_valid,
  output logic                claim,
  output logic [2:0]          claim_win
);
  // legacy ranges: two I/O, one memory
  localparam logic [ADDR_W-1:0] VGA_LO [N_VGA] = '{64'h3B0, 64'h3C0, 64'hA0000};
  localparam logic [ADDR_W-1:0] VGA_HI [N_VGA] = '{64'h3BB, 64'h3DF, 64'hBFFFF};

  win_t [N_WIN-1:0]  wins;
  logic              vga_q;
  logic [ADDR_W-1:0] io_addr;
  logic [N_WIN-1:0]  win_hit;
  logic [N_VGA-1:0]  vga_hit;
  win_e              win_d, win_q;
  logic              claim_d, claim_q, valid_q;

  bwd_window_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd         (cfg_update),
    .io_base_lo  (io_base_lo),
    .io_limit_lo (io_limit_lo),
    .io_base_hi  (io_base_hi),
    .io_limit_hi (io_limit_hi),
    .mem_base    (mem_base),
    .mem_limit   (mem_limit),
    .pf_base     (pf_base),
    .pf_limit    (pf_limit),
    .pf_base_hi  (pf_base_hi),
    .pf_limit_hi (pf_limit_hi),
    .io_en       (cmd_io_en),
    .mem_en      (cmd_mem_en),
    .vga_en      (ctl_vga_en),
    .wins_q      (wins),
    .vga_q       (vga_q)
  );

  assign io_addr = {{(ADDR_W-IO_W){1'b0}}, req_addr[IO_W-1:0]};

  generate
    for (genvar k = 0; k < N_WIN; k++) begin : g_win
      bwd_range_match #(.AW(ADDR_W)) u_match (
        .en    (wins[k].en),
        .base  (wins[k].base),
        .limit (wins[k].limit),
        .addr  ((k == IDX_IO) ? io_addr : req_addr),
        .hit   (win_hit[k])
      );
    end
    for (genvar v = 0; v < N_VGA; v++) begin : g_vga
      bwd_range_match #(.AW(ADDR_W)) u_match (
        .en    (vga_q),
        .base  (VGA_LO[v]),
        .limit (VGA_HI[v]),
        .addr  ((v < 2) ? io_addr : req_addr),
        .hit   (vga_hit[v])
      );
    end
  endgenerate

  // next-state: priority select
  always_comb begin
    win_d = WIN_NONE;
    if (req_valid) begin
      if (req_is_io) begin
        if (win_hit[IDX_IO])              win_d = WIN_IO;
        else if (vga_hit[0] || vga_hit[1]) win_d = WIN_VGA_IO;
      end else begin
        if (win_hit[IDX_PREF])            win_d = WIN_PREF;
        else if (win_hit[IDX_MEM])        win_d = WIN_MEM;
        else if (vga_hit[2])              win_d = WIN_VGA_MEM;
      end
    end
    claim_d = (win_d != WIN_NONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      claim_q <= 1'b0;
      win_q   <= WIN_NONE;
    end else begin
      valid_q <= req_valid;
      claim_q <= claim_d;
      win_q   <= win_d;
    end
  end

  assign claim_valid = valid_q;
  assign claim       = claim_q;
  assign claim_win   = win_q;

  assert_result_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> claim_valid);
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !claim_valid |-> (!claim && claim_win == 3'd0));
  assert_claim_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    claim == (claim_win != 3'd0));
  assert_vga_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && (claim_win == 3'd4 || claim_win == 3'd5)) |-> $past(vga_q));
endmodule

// File: tb/tb_bridge_window_decoder.sv
module tb_bridge_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_update;
  logic [7:0]  io_base_lo, io_limit_lo;
  logic [15:0] io_base_hi, io_limit_hi;
  logic [15:0] mem_base, mem_limit, pf_base, pf_limit;
  logic [31:0] pf_base_hi, pf_limit_hi;
  logic        cmd_io_en, cmd_mem_en, ctl_vga_en;
  logic        req_valid;
  logic [63:0] req_addr;
  logic        req_is_io;
  logic        claim_valid, claim;
  logic [2:0]  claim_win;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // committed shadow copy
  logic [7:0]  s_iob, s_iol;
  logic [15:0] s_iobh, s_iolh, s_mb, s_ml, s_pb, s_pl;
  logic [31:0] s_pbh, s_plh;
  logic        s_io, s_mem, s_vga;

  always #5 clk = ~clk;

  bridge_window_decoder dut (.*);

  function automatic logic [63:0] wbase(input int k);
    logic [63:0] r;
    case (k)
      0: begin r = 64'(s_iob >> 4) * 64'h1000; if (s_iob[3:0] == 4'h1) r = r + 64'(s_iobh) * 64'h10000; end
      1: r = 64'(s_mb >> 4) * 64'h100000;
      default: begin r = 64'(s_pb >> 4) * 64'h100000; if (s_pb[3:0] == 4'h1) r = r + (64'(s_pbh) << 32); end
    endcase
    return r;
  endfunction

  function automatic logic [63:0] wlimit(input int k);
    logic [63:0] r;
    case (k)
      0: begin r = 64'(s_iol >> 4) * 64'h1000 + 64'hFFF; if (s_iol[3:0] == 4'h1) r = r + 64'(s_iolh) * 64'h10000; end
      1: r = 64'(s_ml >> 4) * 64'h100000 + 64'hFFFFF;
      default: begin r = 64'(s_pl >> 4) * 64'h100000 + 64'hFFFFF; if (s_pl[3:0] == 4'h1) r = r + (64'(s_plh) << 32); end
    endcase
    return r;
  endfunction

  function automatic bit inwin(input int k, input logic [63:0] a);
    logic en;
    en = (k == 0) ? s_io : s_mem;
    return en && wbase(k) <= wlimit(k) && a >= wbase(k) && a <= wlimit(k);
  endfunction

  function automatic logic [2:0] model(input logic [63:0] a, input logic io);
    logic [63:0] ia;
    ia = {32'h0, a[31:0]};
    if (io) begin
      if (inwin(0, ia)) return 3'd1;
      if (s_vga && ((ia >= 64'h3B0 && ia <= 64'h3BB) || (ia >= 64'h3C0 && ia <= 64'h3DF))) return 3'd4;
      return 3'd0;
    end
    if (inwin(2, a)) return 3'd3;
    if (inwin(1, a)) return 3'd2;
    if (s_vga && a >= 64'hA0000 && a <= 64'hBFFFF) return 3'd5;
    return 3'd0;
  endfunction

  task automatic commit();
    @(negedge clk);
    cfg_update = 1'b1;
    s_iob = io_base_lo; s_iol = io_limit_lo; s_iobh = io_base_hi; s_iolh = io_limit_hi;
    s_mb = mem_base; s_ml = mem_limit; s_pb = pf_base; s_pl = pf_limit;
    s_pbh = pf_base_hi; s_plh = pf_limit_hi;
    s_io = cmd_io_en; s_mem = cmd_mem_en; s_vga = ctl_vga_en;
    @(negedge clk);
    cfg_update = 1'b0;
  endtask

  task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // issue one request; exp is the expected window code
  task automatic req(input string tag, input logic [63:0] a, input logic io, input logic [2:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_is_io = io;
    @(posedge clk); #1;
    check(tag, {2'b0, claim_valid}, 3'd1);
    check(tag, {2'b0, claim}, {2'b0, exp != 3'd0});
    check(tag, claim_win, exp);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic zero_cfg();
    io_base_lo = 8'hF0; io_limit_lo = 8'h00; io_base_hi = 0; io_limit_hi = 0;
    mem_base = 16'hFFF0; mem_limit = 0; pf_base = 16'hFFF0; pf_limit = 0;
    pf_base_hi = 0; pf_limit_hi = 0;
    cmd_io_en = 0; cmd_mem_en = 0; ctl_vga_en = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_update = 1'b0; req_valid = 1'b0; req_addr = '0; req_is_io = 1'b0;
    zero_cfg();
    io_base_lo = 8'h00; mem_base = 0; pf_base = 0;
    cmd_io_en = 1; cmd_mem_en = 1; ctl_vga_en = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 reset claim_valid", {2'b0, claim_valid}, 3'd0);
    check("R1 reset claim", {2'b0, claim}, 3'd0);
    check("R1 reset win", claim_win, 3'd0);
    @(negedge clk); rst_n = 1'b1;
    // windows disabled until first update, even with enables set
    req("R1 no window before update", 64'hA0000, 1'b0, 3'd0);
    req("R1 no io before update", 64'h0, 1'b1, 3'd0);

    // R10 idle: no request means no result
    @(negedge clk); @(posedge clk); #1;
    check("R10 idle valid", {2'b0, claim_valid}, 3'd0);
    check("R10 idle win", claim_win, 3'd0);

    // R2 I/O window with 32-bit extension: 0x1_2000..0x1_3FFF
    zero_cfg();
    io_base_lo = 8'h21; io_base_hi = 16'h0001; io_limit_lo = 8'h31; io_limit_hi = 16'h0001;
    cmd_io_en = 1;
    commit();
    req("R2 io base", 64'h12000, 1'b1, 3'd1);
    req("R2 io limit", 64'h13FFF, 1'b1, 3'd1);
    req("R2 io above", 64'h14000, 1'b1, 3'd0);
    req("R2 io below", 64'h11FFF, 1'b1, 3'd0);
    req("R2 io upper addr bits ignored", 64'hDEAD_0000_0001_2800, 1'b1, 3'd1);
    req("R2 mem req misses io", 64'h12000, 1'b0, 3'd0);
    // 16-bit type: upper ignored
    io_base_lo = 8'h20; io_limit_lo = 8'h30;
    commit();
    req("R2 io 16-bit base", 64'h2000, 1'b1, 3'd1);
    req("R2 io 16-bit not extended", 64'h12000, 1'b1, 3'd0);

    // R3 memory: 0x1230_0000..0x124F_FFFF
    zero_cfg();
    mem_base = 16'h1230; mem_limit = 16'h1240; cmd_mem_en = 1;
    commit();
    req("R3 mem base", 64'h1230_0000, 1'b0, 3'd2);
    req("R3 mem limit", 64'h124F_FFFF, 1'b0, 3'd2);
    req("R3 mem above", 64'h1250_0000, 1'b0, 3'd0);
    req("R3 mem below", 64'h122F_FFFF, 1'b0, 3'd0);
    req("R3 mem 32-bit only", 64'h1_1230_0000, 1'b0, 3'd0);

    // R4 prefetchable 64-bit: 0x2_0010_0000..0x2_002F_FFFF
    zero_cfg();
    pf_base = 16'h0011; pf_base_hi = 32'h2; pf_limit = 16'h0021; pf_limit_hi = 32'h2; cmd_mem_en = 1;
    commit();
    req("R4 pref base", 64'h2_0010_0000, 1'b0, 3'd3);
    req("R4 pref limit", 64'h2_002F_FFFF, 1'b0, 3'd3);
    req("R4 pref low half only", 64'h0010_0000, 1'b0, 3'd0);

    // R5 enables
    cmd_mem_en = 0; commit();
    req("R5 mem disabled", 64'h2_0010_0000, 1'b0, 3'd0);
    zero_cfg(); io_base_lo = 8'h10; io_limit_lo = 8'h10; cmd_io_en = 0; cmd_mem_en = 1;
    commit();
    req("R5 io disabled", 64'h1000, 1'b1, 3'd0);

    // R6 limit below base
    zero_cfg(); mem_base = 16'h0500; mem_limit = 16'h0400; cmd_mem_en = 1;
    commit();
    req("R6 inverted mem", 64'h0450_0000, 1'b0, 3'd0);
    req("R6 inverted mem at base", 64'h0500_0000, 1'b0, 3'd0);

    // R7 VGA ranges
    zero_cfg(); ctl_vga_en = 1;
    commit();
    req("R7 vga io lo start", 64'h3B0, 1'b1, 3'd4);
    req("R7 vga io lo end", 64'h3BB, 1'b1, 3'd4);
    req("R7 vga io gap", 64'h3BC, 1'b1, 3'd0);
    req("R7 vga io hi end", 64'h3DF, 1'b1, 3'd4);
    req("R7 vga mem end", 64'hBFFFF, 1'b0, 3'd5);
    req("R7 vga mem above", 64'hC0000, 1'b0, 3'd0);
    ctl_vga_en = 0; commit();
    req("R7 vga off", 64'hA0000, 1'b0, 3'd0);

    // R8 priority
    zero_cfg();
    mem_base = 16'h0000; mem_limit = 16'h0010; pf_base = 16'h0010; pf_limit = 16'h0010;
    cmd_mem_en = 1; ctl_vga_en = 1;
    commit();
    req("R8 pref over mem", 64'h0010_0000, 1'b0, 3'd3);
    req("R8 mem over vga", 64'hA0000, 1'b0, 3'd2);
    io_base_lo = 8'h00; io_limit_lo = 8'h00; cmd_io_en = 1;
    commit();
    req("R8 io over vga io", 64'h3C0, 1'b1, 3'd1);

    // R9 changes without update are ignored
    mem_base = 16'hFFF0; cmd_mem_en = 0; ctl_vga_en = 0;
    repeat (2) @(negedge clk);
    req("R9 held pref", 64'h0010_0000, 1'b0, 3'd3);
    req("R9 held mem", 64'h0000_0000, 1'b0, 3'd2);
    commit();
    req("R9 applied after update", 64'h0010_0000, 1'b0, 3'd0);

    // random configurations against the bench model
    for (int it = 0; it < 400; it++) begin
      logic [63:0] a;
      logic io;
      int k;
      io_base_lo  = {4'($urandom), 3'b0, 1'($urandom)};
      io_limit_lo = {4'($urandom), 3'b0, 1'($urandom)};
      io_base_hi  = 16'($urandom % 4);
      io_limit_hi = io_base_hi + 16'($urandom % 2);
      mem_base    = {12'($urandom), 4'h0};
      mem_limit   = mem_base + {12'($urandom % 64), 4'h0};
      pf_base     = {12'($urandom), 3'b0, 1'($urandom)};
      pf_limit    = {pf_base[15:4] + 12'($urandom % 64), 3'b0, 1'($urandom)};
      pf_base_hi  = 32'($urandom % 3);
      pf_limit_hi = pf_base_hi + 32'($urandom % 2);
      cmd_io_en   = ($urandom % 4) != 0;
      cmd_mem_en  = ($urandom % 4) != 0;
      ctl_vga_en  = 1'($urandom);
      commit();
      for (int j = 0; j < 4; j++) begin
        io = 1'($urandom);
        k  = io ? 0 : 1 + int'($urandom % 2);
        case ($urandom % 6)
          0: a = wbase(k);
          1: a = wlimit(k);
          2: a = wbase(k) - 64'd1;
          3: a = wlimit(k) + 64'd1;
          4: a = io ? 64'h3C0 + 64'($urandom % 32) : 64'hA0000 + 64'($urandom % 'h20000);
          default: a = {32'($urandom), 32'($urandom)};
        endcase
        if (io) req("R2 R7 R8 random io", a, 1'b1, model(a, 1'b1));
        else    req("R3 R4 R5 R6 R8 random mem", a, 1'b0, model(a, 1'b0));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule